// File: doc/BRIEF.md
# Programmable Jam-Preset Divide-by-N Counter

This block divides its clock by a programmable ratio N. It emits a pulse one clock wide once every N clocks. The count is held in three parts. A fast first section has a selectable modulus of 2, 4, 5, 8 or 10. Three cascaded decimal decades follow it, each able to start from a preset as high as 15. A thousands-place last section is built from the first-section bits that the chosen modulus does not need. All stages are preset from a 16-bit jam word. The ratio is N = MOD × (1000·L + 100·C + 10·B + A) + F, where F is the first-section preset, A/B/C are the decade presets and L is the last-section preset.

A three-bit mode input selects the first-section modulus, or a master-preset state that loads every stage and holds it there. After master preset ends, one clock arms the counter and countdown starts on the following clock. The first pulse therefore comes one clock later than the steady period. In normal counting, the jam word is reloaded in the same clock that produces the pulse. A latch input can hold the output high after a pulse. The block is used for frequency synthesis prescaling, programmable division and timeouts.

Top module: `divn_counter`

## Requirements
- R1: While `rst` is high, `pulse_out` is 0 and the counter behaves as in master preset. After `rst` falls with a counting mode selected, the first pulse appears on the (N+1)-th rising edge.
- R2: `mode_sel` = {ka,kb,kc}. The code 110 selects modulus 10: F = jam[3:0], with no last section.
- R3: Codes 001 and 010 select modulus 2 (F = jam[0], L = jam[3:1]). Code 011 selects modulus 4 (F = jam[1:0], L = jam[3:2]). Code 111 selects modulus 8 (F = jam[2:0], L = jam[3]).
- R4: Code 101 selects modulus 5: F = jam[2:0], no last section, and jam[3] is ignored.
- R5: Decade presets A = jam[7:4], B = jam[11:8] and C = jam[15:12] may each be up to 15. A decade at 0 that receives a borrow goes to 9. With modulus 8 and all jam bits set, the period is 21327.
- R6: Any code with kb = 0 and kc = 0 is master preset. While it is held, no pulse is produced.
- R7: After master preset is left, the first pulse comes on the (N+1)-th rising edge. Later pulses come every N edges.
- R8: With `latch_en` low, every pulse lasts exactly one clock.
- R9: With `latch_en` high, the output stays high after a pulse until `latch_en` is low at a rising edge.
- R10: A jam change during counting takes effect only at the next reload, which happens on the pulse edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst | input | 1 | Synchronous active-high reset, forces master preset |
| jam | input | 16 | Preset word for all stages |
| mode_sel | input | 3 | {ka,kb,kc} modulus / master-preset select |
| latch_en | input | 1 | Hold output high after a pulse |
| pulse_out | output | 1 | Registered divided output |

## Verification
The assertions assume that the jam word always gives N of at least 3. They also assume that the modulus is changed only by passing through master preset, so the count never runs below one and the last section never underflows. The stimulus enters master preset for at least three clocks before every new mode or jam setting. Its only jam changes during counting are ones whose value still gives N of 3 or more.

// File: rtl/divn_pkg.sv
package divn_pkg;

    localparam int JAM_W     = 16;
    localparam int DIGIT_W   = 4;
    localparam int NUM_DEC   = 3;
    localparam int FRONT_W   = 4;
    localparam int LAST_W    = 3;
    localparam int DEC_BASE  = FRONT_W;

    typedef enum logic [2:0] {
        M_DIV2, M_DIV4, M_DIV5, M_DIV8, M_DIV10, M_PRESET
    } div_mode_e;

    typedef struct packed {
        logic [FRONT_W-1:0] fs;
        logic [LAST_W-1:0]  ls;
        logic [FRONT_W-1:0] top;
    } front_split_t;

    function automatic div_mode_e decode_mode(input logic [2:0] k);
        div_mode_e m;
        if (!k[1] && !k[0]) m = M_PRESET;
        else begin
            case (k)
                3'b001, 3'b010: m = M_DIV2;
                3'b011:         m = M_DIV4;
                3'b101:         m = M_DIV5;
                3'b110:         m = M_DIV10;
                default:        m = M_DIV8;
            endcase
        end
        return m;
    endfunction

    function automatic front_split_t split_front(input div_mode_e m,
                                                 input logic [FRONT_W-1:0] raw);
        front_split_t s;
        case (m)
            M_DIV2:  s = '{fs: {3'b0, raw[0]},   ls: raw[3:1],         top: 4'd1};
            M_DIV4:  s = '{fs: {2'b0, raw[1:0]}, ls: {1'b0, raw[3:2]}, top: 4'd3};
            M_DIV8:  s = '{fs: {1'b0, raw[2:0]}, ls: {2'b0, raw[3]},   top: 4'd7};
            M_DIV5:  s = '{fs: {1'b0, raw[2:0]}, ls: 3'd0,             top: 4'd4};
            default: s = '{fs: raw,              ls: 3'd0,             top: 4'd9};
        endcase
        return s;
    endfunction

    function automatic logic [FRONT_W-1:0] merge_front(input div_mode_e m,
                                                       input logic [FRONT_W-1:0] raw,
                                                       input logic [FRONT_W-1:0] fs,
                                                       input logic [LAST_W-1:0] ls);
        logic [FRONT_W-1:0] r;
        case (m)
            M_DIV2:  r = {ls, fs[0]};
            M_DIV4:  r = {ls[1:0], fs[1:0]};
            M_DIV8:  r = {ls[0], fs[2:0]};
            M_DIV5:  r = {raw[3], fs[2:0]};
            default: r = fs;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/divn_front.sv
module divn_front
    import divn_pkg::*;
(
    input  logic               clk,
    input  logic               load,
    input  logic [FRONT_W-1:0] preset,
    input  div_mode_e          mode,
    input  logic               count_en,
    input  logic               last_dec,
    output logic               fs_zero,
    output logic               fs_one,
    output logic               ls_zero
);

    logic [FRONT_W-1:0] raw_q;
    front_split_t       sp;
    logic [FRONT_W-1:0] fs_next;
    logic [LAST_W-1:0]  ls_next;

    always_comb begin
        sp      = split_front(mode, raw_q);
        fs_zero = (sp.fs == '0);
        fs_one  = (sp.fs == FRONT_W'(1));
        ls_zero = (sp.ls == '0);
        fs_next = fs_zero ? sp.top : sp.fs - FRONT_W'(1);
        ls_next = last_dec ? sp.ls - LAST_W'(1) : sp.ls;
    end

    always_ff @(posedge clk) begin
        if (load)          raw_q <= preset;
        else if (count_en) raw_q <= merge_front(mode, raw_q, fs_next, ls_next);
    end

    // R3
    last_no_underflow_chk: assert property (@(posedge clk) disable iff (load)
        last_dec |-> !ls_zero);

endmodule

// File: rtl/divn_decade.sv
module divn_decade
    import divn_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [DIGIT_W-1:0] preset,
    input  logic               dec_in,
    output logic               is_zero
);

    localparam logic [DIGIT_W-1:0] WRAP_VAL = DIGIT_W'(9);

    logic [DIGIT_W-1:0] digit_q;

    assign is_zero = (digit_q == '0);

    always_ff @(posedge clk) begin
        if (load)        digit_q <= preset;
        else if (dec_in) digit_q <= is_zero ? WRAP_VAL : digit_q - DIGIT_W'(1);
    end

    // R5
    stage_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> digit_q == $past(preset));

    // R5
    decade_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && dec_in && is_zero) |=> digit_q == WRAP_VAL);

endmodule

// File: rtl/divn_out.sv
module divn_out (
    input  logic clk,
    input  logic rst,
    input  logic term,
    input  logic latch_en,
    output logic out_q
);

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= term | (latch_en & out_q);
    end

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (out_q && !latch_en) |=> !out_q);

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_q && latch_en) |=> out_q);

endmodule

// File: rtl/divn_counter.sv
module divn_counter
    import divn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [JAM_W-1:0] jam,
    input  logic [2:0]       mode_sel,
    input  logic             latch_en,
    output logic             pulse_out
);

    div_mode_e          mode;
    logic               preset_mode;
    logic               armed_q;
    logic               count_en;
    logic               load;
    logic               term;
    logic               fs_zero, fs_one, ls_zero;
    logic [NUM_DEC:0]   borrow;
    logic [NUM_DEC-1:0] dec_zero;

    assign mode        = decode_mode(mode_sel);
    assign preset_mode = (mode == M_PRESET);
    assign count_en    = armed_q & ~preset_mode;
    assign term        = count_en & fs_one & ls_zero & (&dec_zero);
    assign load        = rst | preset_mode | term;
    assign borrow[0]   = count_en & fs_zero;

    always_ff @(posedge clk) begin
        if (rst || preset_mode) armed_q <= 1'b0;
        else                    armed_q <= 1'b1;
    end

    divn_front front_i (
        .clk      (clk),
        .load     (load),
        .preset   (jam[FRONT_W-1:0]),
        .mode     (mode),
        .count_en (count_en),
        .last_dec (borrow[NUM_DEC]),
        .fs_zero  (fs_zero),
        .fs_one   (fs_one),
        .ls_zero  (ls_zero)
    );

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
        divn_decade dec_i (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .preset  (jam[DEC_BASE + g*DIGIT_W +: DIGIT_W]),
            .dec_in  (borrow[g]),
            .is_zero (dec_zero[g])
        );
        assign borrow[g+1] = borrow[g] & dec_zero[g];
    end

    divn_out out_i (
        .clk      (clk),
        .rst      (rst),
        .term     (term),
        .latch_en (latch_en),
        .out_q    (pulse_out)
    );

    // R6
    no_early_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        preset_mode |=> !term);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !pulse_out);

endmodule

// File: tb/divn_counter_tb.sv
module divn_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] jam = 16'h0;
    logic [2:0]  mode_sel = 3'b000;
    logic        latch_en = 1'b0;
    logic        pulse_out;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    divn_counter dut_i (
        .clk(clk), .rst(rst), .jam(jam), .mode_sel(mode_sel),
        .latch_en(latch_en), .pulse_out(pulse_out)
    );

    localparam int NV = 9;
    localparam logic [18:0] VEC [NV] = '{
        {3'b110, 16'h0123},
        {3'b111, 16'h001D},
        {3'b011, 16'h0F21},
        {3'b001, 16'h0005},
        {3'b101, 16'h0039},
        {3'b110, 16'h000F},
        {3'b001, 16'h0012},
        {3'b010, 16'h0030},
        {3'b111, 16'h0004}
    };

    function automatic int expect_n(input logic [2:0] k, input logic [15:0] j);
        int m, d1, d5;
        case (k)
            3'b001, 3'b010: begin m = 2;  d1 = int'(j[0]);   d5 = int'(j[3:1]); end
            3'b011:         begin m = 4;  d1 = int'(j[1:0]); d5 = int'(j[3:2]); end
            3'b111:         begin m = 8;  d1 = int'(j[2:0]); d5 = int'(j[3]);   end
            3'b101:         begin m = 5;  d1 = int'(j[2:0]); d5 = 0;            end
            default:        begin m = 10; d1 = int'(j[3:0]); d5 = 0;            end
        endcase
        return m * (1000*d5 + 100*int'(j[15:12]) + 10*int'(j[11:8]) + int'(j[7:4])) + d1;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_pulse(input int start, output int n);
        n = start;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse_out && n < 30000);
    endtask

    task automatic enter_preset(input logic [15:0] j);
        @(negedge clk);
        mode_sel = 3'b000;
        jam = j;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input logic [2:0] k, input logic [15:0] j, input string tag);
        int n, gap, nexp;
        nexp = expect_n(k, j);
        enter_preset(j);
        mode_sel = k;
        wait_pulse(0, n);
        check(n, nexp + 1, {tag, " R7 first latency"});
        @(negedge clk);
        check(int'(pulse_out), 0, {tag, " R8 width"});
        wait_pulse(1, gap);
        check(gap, nexp, {tag, " period"});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n, seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(int'(pulse_out), 0, "R1 reset output");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [2:0] k;
            k = VEC[i][18:16];
            case (k)
                3'b110:  run_vec(k, VEC[i][15:0], "R2 mod10");
                3'b101:  run_vec(k, VEC[i][15:0], "R4 mod5");
                default: run_vec(k, VEC[i][15:0], "R3 mod2/4/8");
            endcase
        end

        // R6 master preset hold, both kb=kc=0 codes
        enter_preset(16'h0004);
        seen = 0;
        for (int c = 0; c < 60; c++) begin
            mode_sel = (c < 30) ? 3'b000 : 3'b100;
            @(negedge clk);
            if (pulse_out) seen++;
        end
        check(seen, 0, "R6 no pulse in preset");

        // R1 reset mid-count acts as preset
        mode_sel = 3'b110; jam = 16'h0020;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(int'(pulse_out), 0, "R1 output during reset");
        rst = 1'b0;
        wait_pulse(0, n);
        check(n, 21, "R1 latency after reset");

        // R10 jam change mid count
        enter_preset(16'h0020);
        mode_sel = 3'b110;
        wait_pulse(0, n);
        jam = 16'h0050;
        wait_pulse(0, n);
        check(n, 20, "R10 old period kept");
        wait_pulse(0, n);
        check(n, 50, "R10 new period at reload");

        // R9 latch hold
        enter_preset(16'h0020);
        mode_sel = 3'b110;
        wait_pulse(0, n);
        latch_en = 1'b1;
        seen = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (!pulse_out) seen++;
        end
        check(seen, 0, "R9 held high");
        latch_en = 1'b0;
        @(negedge clk);
        check(int'(pulse_out), 0, "R9 release");

        // R5 maximum count in modulus 8
        run_vec(3'b111, 16'hFFFF, "R5 max mod8");
        check(expect_n(3'b111, 16'hFFFF), 21327, "R5 equation");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule